// File: doc/BRIEF.md
# Dual-Output Programmable Clock Divider

This block produces two clocks that are locked to one master clock. The reference path divides the master clock by a power of two. The main path divides the master clock by its own power of two and then, unless bypassed, by an integer ratio from 2 to 1025. A third output carries the undivided master clock, so a downstream selector can choose between it and the reference clock.

The block runs from a timing clock `clk_i` at twice the master frequency. One master period is two `clk_i` cycles, and every output is a flop (or a mux of flops) that changes on a `clk_i` rising edge, so divide-by-one is still a registered waveform. Frequency settings may be rewritten while the block runs. Each output picks up a new setting only at its own next rising edge. The period in progress therefore always finishes with the old setting and no shortened pulse appears.

In this brief, "a rise at edge k" means the output is high after `clk_i` rising edge k and was low before it. Mode fields use the encoding 00 = /1, 01 = /2, 10 = /4 and 11 = /8. The divider word W selects a ratio N = W + 2.

Top module: `dual_clk_divider`

## Requirements
- R1: With `ref_mode_i` = m, `ref_o` is high for 2^m `clk_i` cycles and then low for 2^m cycles (encoding 00=/1, 01=/2, 10=/4, 11=/8 of the master clock).
- R2: With `div_bypass_i` = 1 and `main_mode_i` = m, `main_o` is high for 2^m cycles and low for 2^m cycles, using the same encoding as R1.
- R3: With `div_bypass_i` = 0, `main_mode_i` = m and `div_word_i` = W, the period of `main_o` is 2·2^m·(W+2) `clk_i` cycles. W = 0 gives a ratio of 2 and W = 1023 gives a ratio of 1025.
- R4: The bypass bit takes effect at the next rising edge of `main_o`. From that edge, `main_o` follows the prescaler output (bypass = 1) or the divider output (bypass = 0).
- R5: In divided mode, `main_o` is high for ceil(N/2) prescaler periods and low for floor(N/2) prescaler periods. An even N gives 50% duty; an odd N gives a high phase one prescaler period longer than the low phase.
- R6: A change to `ref_mode_i`, `main_mode_i` or `div_word_i` takes effect only at the next rising edge of the output it affects. The period already in progress keeps its old high and low lengths.
- R7: Every rise of `ref_o` or `main_o` falls on a `clk_i` edge where `master_o` also rises.
- R8: While `rst_ni` is low, all three outputs are low. All three rise at the first `clk_i` edge after `rst_ni` is released.
- R9: `master_o` is high for one `clk_i` cycle and low for one `clk_i` cycle, repeating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock at twice the master frequency |
| rst_ni | input | 1 | Synchronous active-low reset |
| ref_mode_i | input | 2 | Reference prescaler mode (00=/1, 01=/2, 10=/4, 11=/8) |
| main_mode_i | input | 2 | Main prescaler mode (same encoding) |
| div_word_i | input | 10 | Divider word W; ratio is W+2 |
| div_bypass_i | input | 1 | 1 routes the main prescaler straight to `main_o` |
| master_o | output | 1 | Undivided master clock |
| ref_o | output | 1 | Reference prescaler output |
| main_o | output | 1 | Main output (prescaler, then divider unless bypassed) |

## Verification
Every output is a register, or a mux of registers whose select is also a register, so a rise that a setting causes appears one `clk_i` edge after that edge samples the inputs. The first rise after reset release comes at edge 1. The bench drives stimulus and samples on falling edges. It measures high and low phase lengths as counts of consecutive samples, starting at the sample where the output was first seen high. A setting written just after a rise is expected to leave the period in progress unchanged and to shape the next period completely. Each on-the-fly check therefore compares two back-to-back measured periods against the old and the new expected values.

// File: rtl/clkdiv_pkg.sv
// Shared widths, types and helpers for the dual-output clock divider.
// Assumes the mode encoding m selects a divide of 2^m on the master clock.
package clkdiv_pkg;
    localparam int unsigned MODE_W   = 2;
    localparam int unsigned WORD_W   = 10;
    localparam int unsigned RAT_W    = WORD_W + 1;
    localparam int unsigned HALF_MAX = 1 << ((1 << MODE_W) - 1);
    localparam int unsigned CNT_W    = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RAT_W-1:0]  ratio_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Last count value of one half-period for a given mode.
    function automatic cnt_t half_last(input mode_t m);
        return cnt_t'((32'd1 << m) - 32'd1);
    endfunction

    // Divider ratio for a divider word: word + 2.
    function automatic ratio_t ratio_of(input word_t w);
        return ratio_t'({1'b0, w}) + ratio_t'(2);
    endfunction
endpackage

// File: rtl/pow2_prescaler.sv
// Power-of-two prescaler. Its output toggles after every 2^m cycles of clk_i,
// which gives a period of 2^m master cycles. It assumes clk_i runs at twice
// the master frequency. The active mode is reloaded only at a rising output
// edge and only when load_i allows it, so no half-period is ever cut short.
module pow2_prescaler
    import clkdiv_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  mode_t mode_i,
    input  logic  load_i,
    output logic  clk_o,
    output logic  rise_o,
    output mode_t mode_o
);
    cnt_t  cnt_q;
    mode_t mode_q;
    logic  lvl_q;
    logic  at_end;

    // End of the current half-period, and the strobe that announces the next rise.
    always_comb begin
        at_end = (cnt_q == half_last(mode_q));
        rise_o = at_end && !lvl_q;
    end

    // Half-period counter, output level and active mode.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q <= mode_i;
            cnt_q  <= half_last(mode_i);
            lvl_q  <= 1'b0;
        end else if (at_end) begin
            lvl_q <= ~lvl_q;
            cnt_q <= '0;
            if (rise_o && load_i) begin
                mode_q <= mode_i;
            end
        end else begin
            cnt_q <= cnt_q + cnt_t'(1);
        end
    end

    assign clk_o  = lvl_q;
    assign mode_o = mode_q;
endmodule

// File: rtl/ratio_divider.sv
// Integer divider that counts the rise strobes of its source clock.
// The output rises at the strobe that ends a period (wrap). It stays high for
// ceil(N/2) strobes and low for floor(N/2). A new ratio is loaded only at wrap.
// While hold_i is set, the divider parks on its last count so the next strobe
// starts a fresh period aligned with the source.
module ratio_divider
    import clkdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  word_t  word_i,
    input  logic   step_i,
    input  logic   hold_i,
    output logic   clk_o,
    output logic   last_o,
    output logic   wrap_o,
    output ratio_t ratio_o
);
    ratio_t ratio_q;
    ratio_t cnt_q;
    ratio_t cnt_inc;
    ratio_t hi_len;
    logic   lvl_q;

    // Count decode and the high-phase length of the active ratio.
    always_comb begin
        last_o  = (cnt_q == ratio_q - ratio_t'(1));
        wrap_o  = step_i && last_o;
        cnt_inc = cnt_q + ratio_t'(1);
        hi_len  = (ratio_q + ratio_t'(1)) >> 1;
    end

    // Period counter, output level and active ratio.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ratio_q <= ratio_of(word_i);
            cnt_q   <= ratio_of(word_i) - ratio_t'(1);
            lvl_q   <= 1'b0;
        end else if (wrap_o) begin
            ratio_q <= ratio_of(word_i);
            cnt_q   <= '0;
            lvl_q   <= 1'b1;
        end else if (hold_i) begin
            cnt_q <= ratio_q - ratio_t'(1);
            lvl_q <= 1'b0;
        end else if (step_i) begin
            cnt_q <= cnt_inc;
            lvl_q <= (cnt_inc < hi_len);
        end
    end

    assign clk_o   = lvl_q;
    assign ratio_o = ratio_q;
endmodule

// File: rtl/dual_clk_divider.sv
// Top level of the dual-output clock divider.
// clk_i runs at twice the master frequency, and master_o toggles on every edge.
// Two prescalers are built from one template. The reference prescaler reloads
// its mode at each of its own rises. The main prescaler reloads only at a rise
// of main_o. The divider and the bypass select are updated on those same edges.
module dual_clk_divider
    import clkdiv_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  mode_t ref_mode_i,
    input  mode_t main_mode_i,
    input  word_t div_word_i,
    input  logic  div_bypass_i,
    output logic  master_o,
    output logic  ref_o,
    output logic  main_o
);
    localparam int unsigned NUM_PRE = 2;

    mode_t               pre_mode [NUM_PRE];
    mode_t               act_mode [NUM_PRE];
    logic  [NUM_PRE-1:0] pre_load;
    logic  [NUM_PRE-1:0] pre_clk;
    logic  [NUM_PRE-1:0] pre_rise;

    logic   master_q;
    logic   bypass_q;
    logic   div_clk;
    logic   div_last;
    logic   div_wrap;
    logic   main_rise;
    ratio_t div_ratio;

    // Mode inputs and reload permissions for the two prescalers.
    always_comb begin
        pre_mode[0] = ref_mode_i;
        pre_mode[1] = main_mode_i;
        pre_load[0] = 1'b1;
        pre_load[1] = bypass_q | div_last;
    end

    for (genvar g = 0; g < NUM_PRE; g++) begin : g_pre
        pow2_prescaler u_pre (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .mode_i (pre_mode[g]),
            .load_i (pre_load[g]),
            .clk_o  (pre_clk[g]),
            .rise_o (pre_rise[g]),
            .mode_o (act_mode[g])
        );
    end

    ratio_divider u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .word_i  (div_word_i),
        .step_i  (pre_rise[1]),
        .hold_i  (bypass_q),
        .clk_o   (div_clk),
        .last_o  (div_last),
        .wrap_o  (div_wrap),
        .ratio_o (div_ratio)
    );

    // Strobe for the next rising edge of main_o in the active routing.
    assign main_rise = bypass_q ? pre_rise[1] : div_wrap;

    // Master clock at half the clk_i rate.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            master_q <= 1'b0;
        end else begin
            master_q <= ~master_q;
        end
    end

    // Bypass select, reloaded only at a rising edge of main_o.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bypass_q <= div_bypass_i;
        end else if (main_rise) begin
            bypass_q <= div_bypass_i;
        end
    end

    assign master_o = master_q;
    assign ref_o    = pre_clk[0];
    assign main_o   = bypass_q ? pre_clk[1] : div_clk;
endmodule

// File: rtl/dual_clk_divider_chk.sv
// Checker for dual_clk_divider: phase alignment of rises, setting changes
// confined to rising edges, and reset levels. It is attached by bind below.
module dual_clk_divider_chk
    import clkdiv_pkg::*;
(
    input logic   clk_i,
    input logic   rst_ni,
    input logic   master_o,
    input logic   ref_o,
    input logic   main_o,
    input logic   ref_rise,
    input logic   byp_act,
    input mode_t  ref_mode_act,
    input mode_t  main_mode_act,
    input ratio_t ratio_act
);
    // R8: reset forces every output low on the following edge.
    a_r8_reset_low: assert property (@(posedge clk_i)
        !rst_ni |=> (!master_o && !ref_o && !main_o));

    // R7: the main output rises only together with the master clock.
    a_r7_main_on_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(main_o) |-> $rose(master_o));

    // R7: the reference output rises only together with the master clock.
    a_r7_ref_on_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ref_o) |-> $rose(master_o));

    // R7: a pending reference rise always meets a low master clock.
    a_r7_ref_strobe_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_rise |-> !master_o);

    // R6: the reference mode changes only where ref_o rises.
    a_r6_ref_mode_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ref_mode_act) |-> $rose(ref_o));

    // R6: the main prescaler mode changes only where main_o rises.
    a_r6_main_mode_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(main_mode_act) |-> $rose(main_o));

    // R6: the divider ratio changes only where main_o rises.
    a_r6_ratio_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ratio_act) |-> $rose(main_o));

    // R4: the routing of main_o switches only where main_o rises.
    a_r4_bypass_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(byp_act) |-> $rose(main_o));
endmodule

bind dual_clk_divider dual_clk_divider_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .master_o      (master_o),
    .ref_o         (ref_o),
    .main_o        (main_o),
    .ref_rise      (pre_rise[0]),
    .byp_act       (bypass_q),
    .ref_mode_act  (act_mode[0]),
    .main_mode_act (act_mode[1]),
    .ratio_act     (div_ratio)
);

// File: tb/sim_dual_clk_divider.sv
// Directed bench for dual_clk_divider. Inputs change and outputs are sampled
// on falling clk edges. Phase lengths are counted in clk cycles.
module sim_dual_clk_divider;
    import clkdiv_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic  clk;
    logic  rst_n;
    mode_t ref_mode;
    mode_t main_mode;
    word_t word;
    logic  bypass;
    logic  master_o, ref_o, main_o;

    int n_run  = 0;
    int n_fail = 0;

    dual_clk_divider u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .ref_mode_i   (ref_mode),
        .main_mode_i  (main_mode),
        .div_word_i   (word),
        .div_bypass_i (bypass),
        .master_o     (master_o),
        .ref_o        (ref_o),
        .main_o       (main_o)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    function automatic logic get(input int sel);
        case (sel)
            0:       return ref_o;
            1:       return main_o;
            default: return master_o;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_rise(input int sel);
        logic prev, cur;
        prev = get(sel);
        @(negedge clk);
        cur = get(sel);
        while (!(cur && !prev)) begin
            prev = cur;
            @(negedge clk);
            cur = get(sel);
        end
    endtask

    // Starts at a sample where sel has just risen and ends at its next rise.
    task automatic count_period(input int sel, output int hi, output int lo);
        hi = 1;
        @(negedge clk);
        while (get(sel)) begin
            hi++;
            @(negedge clk);
        end
        lo = 1;
        @(negedge clk);
        while (!get(sel)) begin
            lo++;
            @(negedge clk);
        end
    endtask

    task automatic check_period(input int sel, input int ehi, input int elo, input string tag);
        int hi, lo;
        count_period(sel, hi, lo);
        check({tag, " high"}, hi, ehi);
        check({tag, " low"}, lo, elo);
    endtask

    function automatic int div_hi(input int m, input int w);
        return ((w + 3) / 2) * 2 * (1 << m);
    endfunction

    function automatic int div_lo(input int m, input int w);
        return ((w + 2) / 2) * 2 * (1 << m);
    endfunction

    // R8 and R9: reset levels, the first rise after release, master period.
    task automatic t_reset();
        ref_mode = 2'b00; main_mode = 2'b00; word = '0; bypass = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 outputs in reset", {29'd0, master_o, ref_o, main_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 outputs after first edge", {29'd0, master_o, ref_o, main_o}, 7);
        check_period(2, 1, 1, "R9 master");
    endtask

    // R1: every reference mode.
    task automatic t_ref_modes();
        for (int m = 0; m < 4; m++) begin
            ref_mode = mode_t'(m);
            wait_rise(0);
            check_period(0, 1 << m, 1 << m, $sformatf("R1 ref mode %0d", m));
        end
    endtask

    // R2 with R4: the main prescaler alone, divider bypassed.
    task automatic t_bypass();
        bypass = 1'b1;
        for (int m = 0; m < 4; m++) begin
            main_mode = mode_t'(m);
            wait_rise(1);
            check_period(1, 1 << m, 1 << m, $sformatf("R2 bypass mode %0d", m));
        end
    endtask

    // R3 and R5: divider ratios, including the smallest and the largest.
    task automatic t_div();
        int modes [5] = '{0, 0, 1, 0, 3};
        int words [5] = '{0, 1, 5, 1023, 2};
        bypass = 1'b0;
        for (int i = 0; i < 5; i++) begin
            main_mode = mode_t'(modes[i]);
            word = word_t'(words[i]);
            wait_rise(1);
            check_period(1, div_hi(modes[i], words[i]), div_lo(modes[i], words[i]),
                         $sformatf("R3/R5 mode %0d word %0d", modes[i], words[i]));
        end
    endtask

    // R6 and R4: settings written just after a rise reshape only the next period.
    task automatic t_fly();
        int hi, lo;
        main_mode = 2'b00; word = word_t'(3); bypass = 1'b0;
        wait_rise(1);
        count_period(1, hi, lo);
        main_mode = 2'b01; word = '0;
        check_period(1, 6, 4, "R6 main old period");
        check_period(1, 4, 4, "R6 main new period");

        ref_mode = 2'b00;
        wait_rise(0);
        ref_mode = 2'b11;
        check_period(0, 1, 1, "R6 ref old period");
        check_period(0, 8, 8, "R6 ref new period");

        main_mode = 2'b00; word = word_t'(1);
        wait_rise(1);
        bypass = 1'b1;
        check_period(1, 4, 2, "R4 divided before bypass");
        check_period(1, 1, 1, "R4 bypassed after switch");
        bypass = 1'b0;
        check_period(1, 1, 1, "R4 bypassed before switch");
        check_period(1, 4, 2, "R4 divided after switch");
    endtask

    // R7: every rise of ref_o and main_o coincides with a rise of master_o.
    task automatic t_sync();
        int bad = 0;
        int seen = 0;
        logic pm, pr, pn;
        ref_mode = 2'b01; main_mode = 2'b10; word = word_t'(2); bypass = 1'b0;
        pm = master_o; pr = ref_o; pn = main_o;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if ((ref_o && !pr) || (main_o && !pn)) begin
                seen++;
                if (!(master_o && !pm)) bad++;
            end
            pm = master_o; pr = ref_o; pn = main_o;
        end
        check("R7 misaligned rises", bad, 0);
        check("R7 rises observed", (seen > 10) ? 1 : 0, 1);
    endtask

    initial begin
        ref_mode = '0; main_mode = '0; word = '0; bypass = 1'b0; rst_n = 1'b0;
        t_reset();
        t_ref_modes();
        t_bypass();
        t_div();
        t_fly();
        t_sync();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected fewer", WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule